// File: doc/BRIEF.md
# Two-Pointer Remap Table Controller

This block is the address-redirection table of a self-repairing, ECC-protected embedded memory. Each of its entries remembers one faulty word address and is permanently tied to one spare word, identified by the entry's index. During normal operation every access address is compared against all live entries in one cycle. On a match the block raises a redirect flag and gives the index of the spare word to use in place of the faulty one.

While the memory is idle and under self-test, a diagnosis source reports faulty words one at a time. Each report carries the address and whether the word showed exactly one error or two or more. Words with several errors cannot be saved by single-error correction, so they take priority. They fill the table from entry 0 upward. Single-error words, which correction can still save, fill it from the last entry downward. When the two regions meet, a multi-error word displaces the most recently placed single-error word. A single-error word that finds no room is left to the error-correcting code. If a multi-error word arrives with no room and nothing left to displace, a sticky flag reports that the memory can no longer be repaired.

Top module: `remap_cam_ctl`

## Requirements
- R1: After reset no lookup address hits, spare_idx is 0, unrepairable is 0, and the table holds no entries.
- R2: With test_mode=0, a lookup address equal to a stored entry gives hit=1 and spare_idx equal to that entry's index, in the same cycle. Any other address gives hit=0 and spare_idx=0.
- R3: With test_mode=1, hit and spare_idx stay 0. With test_mode=0, an insertion request (ins_valid=1) changes nothing.
- R4: A new address reported with ins_multi=1 (two or more errors) while free entries remain is stored at the lowest unused index. The first such address gets index 0, the next index 1, and so on.
- R5: A new address reported with ins_multi=0 (exactly one error) while free entries remain is stored at the highest unused index. The first such address gets index DEPTH-1, the next DEPTH-2, and so on.
- R6: The table is full when the multi-error count plus the single-error count equals DEPTH. A new single-error report into a full table is dropped and no lookup result changes.
- R7: A new multi-error report into a full table that holds at least one single-error entry cancels the most recently stored single-error entry, whose address then misses. The new address takes that entry's index, and the multi-error region grows by one.
- R8: A new multi-error report into a full table with no single-error entries stores nothing and sets unrepairable to 1. It stays 1 until reset.
- R9: Reporting an address that is already stored, in a class no higher than its entry's class, changes nothing. No address is ever stored twice.
- R10: Reporting a stored single-error address with ins_multi=1 upgrades it. The most recent single-error entry moves to the upgraded entry's index (or vanishes if it was that entry). The upgraded address is then stored at the lowest unused index, as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| test_mode | input | 1 | 1: insertion enabled, lookups off; 0: lookups on |
| lk_addr | input | ADDR_W | Access address to redirect |
| ins_valid | input | 1 | Insertion request this cycle |
| ins_addr | input | ADDR_W | Faulty word address to record |
| ins_multi | input | 1 | 1: two or more errors; 0: exactly one error |
| hit | output | 1 | Access address is redirected |
| spare_idx | output | $clog2(DEPTH) | Spare word index for a redirected access |
| unrepairable | output | 1 | Sticky: a multi-error word could not be placed |

## Verification
The functions that share a cycle are the cancellation of a single-error entry and the write of a multi-error address. In the full-table eviction they hit the same slot. In the upgrade they can hit two different slots, together with a move. The bench provokes both by filling the table until the pointers meet, then issuing multi-error reports: new ones and ones that re-report stored single-error addresses, including the most recent one. After every insertion it sweeps the whole lookup address space in normal mode and compares each hit and index against a table rebuilt in the bench from the requirements.

// File: rtl/remap_pkg.sv
package remap_pkg;

    // Decision taken for one insertion request
    typedef enum logic [2:0] {
        ACT_IDLE,       // no request
        ACT_PUT_ONE,    // single-error word into top region
        ACT_PUT_MULTI,  // multi-error word into bottom region
        ACT_EVICT,      // full: cancel newest single entry, reuse slot
        ACT_UPGRADE,    // stored single-error word re-reported as multi
        ACT_KEEP,       // already stored, nothing to do
        ACT_DROP,       // single-error word, no room
        ACT_FAIL        // multi-error word, no room, nothing to evict
    } ins_act_e;

endpackage

// File: rtl/remap_match.sv
module remap_match #(
    parameter int ADDR_W = 10,
    parameter int DEPTH  = 8
) (
    input  logic [DEPTH-1:0][ADDR_W-1:0] tags,
    input  logic [DEPTH-1:0]             vld,
    input  logic [ADDR_W-1:0]            key,
    output logic [DEPTH-1:0]             eq
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign eq[i] = vld[i] && (tags[i] == key);
    end

endmodule

// File: rtl/remap_enc.sv
module remap_enc #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic [DEPTH-1:0] vec,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    // vec is at most one-hot, so OR-ing indices gives the position
    always_comb begin
        idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            idx = idx | (vec[i] ? IDX_W'(i) : '0);
        end
        any = |vec;
    end

endmodule

// File: rtl/remap_ctrl.sv
module remap_ctrl
    import remap_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DEPTH  = 8,
    parameter int IDX_W  = 3,
    parameter int CNT_W  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ins_fire,
    input  logic                         ins_multi,
    input  logic [ADDR_W-1:0]            ins_addr,
    input  logic                         hit_any,
    input  logic [IDX_W-1:0]             hit_idx,
    output logic [DEPTH-1:0][ADDR_W-1:0] tags,
    output logic [DEPTH-1:0]             vld,
    output logic [CNT_W-1:0]             p2,
    output logic [CNT_W-1:0]             top,
    output logic                         unrep
);

    // p2  : next slot for multi-error words (grows upward from 0)
    // top : one above the next slot for single-error words
    //       (single entries occupy top .. DEPTH-1)
    // full when p2 == top
    typedef struct packed {
        logic [DEPTH-1:0][ADDR_W-1:0] tag;
        logic [DEPTH-1:0]             vld;
        logic [CNT_W-1:0]             p2;
        logic [CNT_W-1:0]             top;
        logic                         unrep;
    } state_t;

    localparam state_t ST_RST = '{
        tag:   '0,
        vld:   '0,
        p2:    '0,
        top:   CNT_W'(DEPTH),
        unrep: 1'b0
    };

    state_t     st_d, st_q;
    ins_act_e   act;
    logic       full, have_one, hit_low;
    logic [IDX_W-1:0] wr_slot, top_slot, p2_slot;

    always_comb begin
        st_d     = st_q;
        act      = ACT_IDLE;
        full     = (st_q.p2 >= st_q.top);
        have_one = (st_q.top < CNT_W'(DEPTH));
        hit_low  = (CNT_W'(hit_idx) < st_q.p2);
        top_slot = IDX_W'(st_q.top);
        p2_slot  = IDX_W'(st_q.p2);
        wr_slot  = p2_slot;

        if (ins_fire) begin
            if (hit_any) begin
                act = (hit_low || !ins_multi) ? ACT_KEEP : ACT_UPGRADE;
            end else if (!ins_multi) begin
                act = full ? ACT_DROP : ACT_PUT_ONE;
            end else if (!full) begin
                act = ACT_PUT_MULTI;
            end else if (have_one) begin
                act = ACT_EVICT;
            end else begin
                act = ACT_FAIL;
            end
        end

        case (act)
            ACT_PUT_ONE: begin
                wr_slot  = IDX_W'(st_q.top - CNT_W'(1));
                st_d.top = st_q.top - CNT_W'(1);
            end
            ACT_PUT_MULTI: begin
                st_d.p2 = st_q.p2 + CNT_W'(1);
            end
            ACT_EVICT: begin
                // cancel newest single entry; its slot equals p2 here
                st_d.vld[top_slot] = 1'b0;
                st_d.p2  = st_q.p2 + CNT_W'(1);
                st_d.top = st_q.top + CNT_W'(1);
            end
            ACT_UPGRADE: begin
                // close the hole: newest single entry moves into it
                st_d.tag[hit_idx]  = st_q.tag[top_slot];
                st_d.vld[top_slot] = 1'b0;
                st_d.p2  = st_q.p2 + CNT_W'(1);
                st_d.top = st_q.top + CNT_W'(1);
            end
            ACT_FAIL: begin
                st_d.unrep = 1'b1;
            end
            default: ;
        endcase

        if (act == ACT_PUT_ONE || act == ACT_PUT_MULTI ||
            act == ACT_EVICT   || act == ACT_UPGRADE) begin
            st_d.tag[wr_slot] = ins_addr;
            st_d.vld[wr_slot] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign tags  = st_q.tag;
    assign vld   = st_q.vld;
    assign p2    = st_q.p2;
    assign top   = st_q.top;
    assign unrep = st_q.unrep;

endmodule

// File: rtl/remap_cam_ctl.sv
module remap_cam_ctl #(
    parameter int ADDR_W = 10,
    parameter int DEPTH  = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_mode,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              ins_valid,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic              ins_multi,
    output logic              hit,
    output logic [IDX_W-1:0]  spare_idx,
    output logic              unrepairable
);

    logic [DEPTH-1:0][ADDR_W-1:0] tags_w;
    logic [DEPTH-1:0]             vld_w;
    logic [DEPTH-1:0]             eq_w;
    logic [CNT_W-1:0]             p2_w, top_w;
    logic [ADDR_W-1:0]            key_w;
    logic [IDX_W-1:0]             idx_w;
    logic                         any_w;

    // one compare array serves both modes
    assign key_w = test_mode ? ins_addr : lk_addr;

    remap_match #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_match (
        .tags (tags_w),
        .vld  (vld_w),
        .key  (key_w),
        .eq   (eq_w)
    );

    remap_enc #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_enc (
        .vec (eq_w),
        .idx (idx_w),
        .any (any_w)
    );

    remap_ctrl #(
        .ADDR_W(ADDR_W), .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ins_fire  (test_mode && ins_valid),
        .ins_multi (ins_multi),
        .ins_addr  (ins_addr),
        .hit_any   (any_w),
        .hit_idx   (idx_w),
        .tags      (tags_w),
        .vld       (vld_w),
        .p2        (p2_w),
        .top       (top_w),
        .unrep     (unrepairable)
    );

    assign hit       = !test_mode && any_w;
    assign spare_idx = hit ? idx_w : '0;

endmodule

// File: rtl/remap_chk.sv
module remap_chk #(
    parameter int ADDR_W = 10,
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         test_mode,
    input logic                         ins_valid,
    input logic                         ins_multi,
    input logic                         unrepairable,
    input logic [CNT_W-1:0]             p2,
    input logic [CNT_W-1:0]             top,
    input logic [DEPTH-1:0]             vld,
    input logic [DEPTH-1:0]             eq,
    input logic [DEPTH-1:0][ADDR_W-1:0] tags
);

    // R6
    ptr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        p2 <= top);

    // R9
    no_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eq));

    // R3
    frozen_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |=> $stable(vld) && $stable(tags) && $stable(p2) && $stable(top));

    // R6
    drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode && ins_valid && !ins_multi && (p2 == top)
        |=> $stable(vld) && $stable(p2) && $stable(top));

    // R4
    multi_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode && ins_valid && ins_multi && !(|eq) && (p2 < top)
        |=> (p2 == $past(p2) + CNT_W'(1)) && $stable(top));

    // R7
    evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode && ins_valid && ins_multi && !(|eq) && (p2 == top) && (top < CNT_W'(DEPTH))
        |=> (p2 == $past(p2) + CNT_W'(1)) && (top == $past(top) + CNT_W'(1)));

    // R8
    unrep_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode && ins_valid && ins_multi && !(|eq) && (p2 == CNT_W'(DEPTH))
        |=> unrepairable && $stable(vld));

    // R8
    unrep_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unrepairable |=> unrepairable);

endmodule

bind remap_cam_ctl remap_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .test_mode    (test_mode),
    .ins_valid    (ins_valid),
    .ins_multi    (ins_multi),
    .unrepairable (unrepairable),
    .p2           (p2_w),
    .top          (top_w),
    .vld          (vld_w),
    .eq           (eq_w),
    .tags         (tags_w)
);

// File: tb/sim_remap_cam_ctl.sv
module sim_remap_cam_ctl;

    localparam int CLK_P = 10;
    localparam int AW    = 6;
    localparam int D     = 8;
    localparam int IW    = $clog2(D);
    localparam int NADDR = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          test_mode = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic          ins_valid = 1'b0;
    logic [AW-1:0] ins_addr = '0;
    logic          ins_multi = 1'b0;
    logic          hit;
    logic [IW-1:0] spare_idx;
    logic          unrepairable;

    int n_run = 0;
    int n_fail = 0;

    // expected table, rebuilt from the requirements
    logic [AW-1:0] m_tag [D];
    bit            m_vld [D];
    int            m_nmul;   // entries 0 .. m_nmul-1 hold multi-error words
    int            m_none;   // entries D-m_none .. D-1 hold single-error words
    bit            m_unrep;

    always #(CLK_P/2) clk = ~clk;

    remap_cam_ctl #(.ADDR_W(AW), .DEPTH(D)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .test_mode    (test_mode),
        .lk_addr      (lk_addr),
        .ins_valid    (ins_valid),
        .ins_addr     (ins_addr),
        .ins_multi    (ins_multi),
        .hit          (hit),
        .spare_idx    (spare_idx),
        .unrepairable (unrepairable)
    );

    initial begin
        #(CLK_P * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run did not finish (expected completion)");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    function automatic int m_find(logic [AW-1:0] a);
        for (int i = 0; i < D; i++) if (m_vld[i] && m_tag[i] == a) return i;
        return -1;
    endfunction

    task automatic m_clear();
        for (int i = 0; i < D; i++) begin m_vld[i] = 0; m_tag[i] = '0; end
        m_nmul = 0; m_none = 0; m_unrep = 0;
    endtask

    task automatic m_put(int slot, logic [AW-1:0] a);
        m_tag[slot] = a; m_vld[slot] = 1;
    endtask

    // expected effect of one report
    task automatic m_insert(logic [AW-1:0] a, bit multi);
        int h;
        int newest;
        h = m_find(a);
        newest = D - m_none;
        if (h >= 0) begin
            if (h < m_nmul || !multi) return;            // R9
            m_tag[h] = m_tag[newest]; m_vld[newest] = 0;  // R10
            m_none--;
            m_put(m_nmul, a); m_nmul++;
            return;
        end
        if (m_nmul + m_none < D) begin
            if (multi) begin m_put(m_nmul, a); m_nmul++; end                 // R4
            else begin m_put(D - 1 - m_none, a); m_none++; end               // R5
        end else if (multi) begin
            if (m_none > 0) begin m_vld[newest] = 0; m_put(m_nmul, a); m_nmul++; m_none--; end // R7
            else m_unrep = 1;                                                 // R8
        end                                                                   // R6 drop
    endtask

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; test_mode = 0; ins_valid = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
        m_clear();
        #1;
    endtask

    task automatic report(logic [AW-1:0] a, bit multi);
        @(negedge clk);
        test_mode = 1; ins_valid = 1; ins_addr = a; ins_multi = multi;
        @(posedge clk);
        #1;
        ins_valid = 0;
        m_insert(a, multi);
    endtask

    task automatic look(logic [AW-1:0] a, bit eh, int ei, string req);
        test_mode = 0; lk_addr = a; #1;
        chk(hit == eh, req, "hit", int'(hit), int'(eh));
        chk(int'(spare_idx) == ei, req, "spare_idx", int'(spare_idx), ei);
    endtask

    // full sweep of the lookup space against the expected table
    task automatic sweep(string req);
        bit bad;
        int first;
        int ah;
        int ai;
        int eh;
        int ei;
        bad = 0; first = -1; ah = 0; ai = 0; eh = 0; ei = 0;
        test_mode = 0;
        for (int a = 0; a < NADDR; a++) begin
            int h;
            lk_addr = AW'(a); #1;
            h = m_find(AW'(a));
            if ((hit != (h >= 0)) || (int'(spare_idx) != ((h >= 0) ? h : 0))) begin
                if (!bad) begin
                    first = a; ah = int'(hit); ai = int'(spare_idx);
                    eh = (h >= 0); ei = (h >= 0) ? h : 0;
                end
                bad = 1;
            end
        end
        chk(!bad, req, $sformatf("sweep addr %0d hit", first), ah, eh);
        if (bad) chk(0, req, "sweep spare_idx", ai, ei);
        chk(unrepairable == m_unrep, req, "unrepairable", int'(unrepairable), int'(m_unrep));
    endtask

    initial begin
        m_clear();
        do_reset();

        // R1: nothing stored after reset
        sweep("R1");
        look(6'd0, 0, 0, "R1");

        // R4 / R5: two regions
        report(6'd10, 1);
        report(6'd20, 1);
        report(6'd30, 0);
        report(6'd40, 0);
        report(6'd50, 1);
        look(6'd10, 1, 0, "R4");
        look(6'd20, 1, 1, "R4");
        look(6'd50, 1, 2, "R4");
        look(6'd30, 1, 7, "R5");
        look(6'd40, 1, 6, "R5");
        look(6'd11, 0, 0, "R2");
        sweep("R2");

        // R3: lookups off in test mode
        test_mode = 1; lk_addr = 6'd10; #1;
        chk(hit == 0, "R3", "hit in test mode", int'(hit), 0);
        chk(spare_idx == 0, "R3", "spare_idx in test mode", int'(spare_idx), 0);
        // R3: request ignored in normal mode
        @(negedge clk);
        test_mode = 0; ins_valid = 1; ins_addr = 6'd60; ins_multi = 1;
        @(posedge clk); #1; ins_valid = 0;
        look(6'd60, 0, 0, "R3");
        sweep("R3");

        // R6: fill, then drop a single-error word
        report(6'd1, 0);
        report(6'd2, 0);
        report(6'd3, 0);
        look(6'd3, 1, 3, "R6");
        report(6'd4, 0);
        look(6'd4, 0, 0, "R6");
        sweep("R6");

        // R7: evictions, newest single first
        report(6'd5, 1);
        look(6'd3, 0, 0, "R7");
        look(6'd5, 1, 3, "R7");
        sweep("R7");
        report(6'd6, 1);
        look(6'd2, 0, 0, "R7");
        look(6'd6, 1, 4, "R7");
        report(6'd7, 1);
        report(6'd8, 1);
        report(6'd9, 1);
        sweep("R7");

        // R8: nothing left to evict
        report(6'd12, 1);
        look(6'd12, 0, 0, "R8");
        chk(unrepairable == 1, "R8", "unrepairable set", int'(unrepairable), 1);
        report(6'd10, 1);
        chk(unrepairable == 1, "R8", "unrepairable sticky", int'(unrepairable), 1);
        sweep("R8");

        // R9 / R10: duplicates and upgrades
        do_reset();
        report(6'd21, 1);
        report(6'd22, 0);
        report(6'd23, 0);
        report(6'd24, 0);
        report(6'd21, 1);
        report(6'd21, 0);
        report(6'd23, 0);
        look(6'd21, 1, 0, "R9");
        look(6'd23, 1, 6, "R9");
        sweep("R9");
        report(6'd23, 1);   // middle single upgraded; newest (24 at 5) moves to 6
        look(6'd23, 1, 1, "R10");
        look(6'd24, 1, 6, "R10");
        sweep("R10");
        report(6'd24, 1);   // newest single upgraded
        look(6'd24, 1, 2, "R10");
        sweep("R10");
        // upgrade into a full table
        report(6'd25, 0);
        report(6'd26, 0);
        report(6'd27, 0);
        report(6'd28, 0);
        report(6'd29, 0);
        report(6'd22, 1);
        look(6'd22, 1, 3, "R10");
        sweep("R10");

        // mixed sweeps over many report sequences
        for (int r = 0; r < 6; r++) begin
            do_reset();
            for (int k = 0; k < 24; k++) begin
                int a;
                a = (k * 37 + r * 11 + (k * k) % 7) % 24;
                report(AW'(a), ((k * 5 + r) % 3) != 0);
                sweep("R7");
            end
        end

        do_reset();
        sweep("R1");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule